// File: doc/BRIEF.md
# Encoded Interrupt Level Input Filter

This block receives external interrupt requests that arrive as encoded priority codes rather than one wire per source. Each of two independent groups has four active-low pins, driven by an off-chip priority encoder. The pins are asynchronous, so each group first passes through a synchronizer. The block then qualifies the code: a new value is taken only after the same pattern has been seen on three consecutive bus-clock samples. This keeps a half-switched pattern, seen while the encoder's outputs are changing, from ever reaching the interrupt logic.

For each group, the accepted pattern is turned into a 4-bit priority level: the bitwise inverse of the pins. A request-valid flag shows whether that level is nonzero. The block drives the level and the flag to downstream interrupt arbitration. Masking, acknowledge and vectoring are handled elsewhere.

Top module: `elf_level_filter`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every group's level is 0 and its valid flag is low.
- R2: An accepted pattern gives a level equal to the bitwise inverse of the four pins. All pins low gives 15, and pins 1011 (pin 3 first) give 4.
- R3: The all-high pattern (1111) is level 0. With that pattern accepted, the group's valid flag is low.
- R4: A group's valid flag is high exactly when its level is nonzero. Both change on the same clock edge.
- R5: The two groups are decoded independently. Group 0 is pins 3..0 and group 1 is pins 7..4 of the pin bus and of the level bus. A change on one group never alters the other group's outputs.
- R6: Suppose a pattern is applied before rising edge 1 and then held. It appears on the outputs right after rising edge 5, which comes from 2 synchronizer stages plus 3 matching samples. The outputs do not change after edges 1 to 4.
- R7: A pattern held for fewer than three consecutive samples is never accepted. The previously accepted level and flag stay on the outputs.
- R8: If the pattern changes before three matching samples have been collected, the count starts again. A pattern that returns after an interruption needs three new consecutive samples before it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; pins are sampled on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_n_i | input | 8 | Active-low encoded pins; group g occupies bits 4g+3..4g |
| level_o | output | 8 | Accepted priority level per group, same bit layout as the pins |
| req_valid_o | output | 2 | Per-group request flag, high when that group's level is nonzero |

## Verification
The assertions assume the pins are stable relative to the clock edge once synchronized. They also assume that the reset value of the history, all high, is a legal "no request" pattern. As a result, the first samples after reset compare against an idle code and never against stale data. The bench changes the pins only on falling clock edges. It holds the pins all high while reset is asserted. The bench's random phase changes each group at random moments, so runs of one, two and three or more identical samples all appear. This exercises both rejected glitches and accepted levels. It never relies on metastable behaviour.

// File: rtl/elf_pkg.sv
package elf_pkg;

   // Electrical sense of the encoded pins.
   typedef enum logic {
      POL_HIGH = 1'b0,
      POL_LOW  = 1'b1
   } pin_pol_e;

   localparam int unsigned MAX_CODE_W      = 16;
   localparam int unsigned MAX_SYNC_STAGES = 4;

   // Code that a group shows when no source requests service.
   function automatic logic [MAX_CODE_W-1:0] idle_code(input pin_pol_e pol);
      return (pol == POL_LOW) ? {MAX_CODE_W{1'b1}} : {MAX_CODE_W{1'b0}};
   endfunction

endpackage

// File: rtl/elf_pin_sync.sv
module elf_pin_sync #(
   parameter int unsigned  WIDTH   = 4,
   parameter int unsigned  STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("elf_pin_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) begin
               stage_q[s] <= RST_VAL;
            end
         end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/elf_match_qual.sv
module elf_match_qual #(
   parameter int unsigned      WIDTH   = 4,
   parameter int unsigned      SAMPLES = 3,
   parameter logic [WIDTH-1:0] IDLE    = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sample_i,
   output logic [WIDTH-1:0] acc_code_o,
   output logic             acc_req_o
);

   localparam int unsigned HIST_D = SAMPLES - 1;

   if (SAMPLES < 2) begin : g_bad_samples
      $error("elf_match_qual: SAMPLES must be at least 2");
   end

   logic [WIDTH-1:0] hist_q [HIST_D];
   logic [WIDTH-1:0] acc_code_q;
   logic             acc_req_q;
   logic             all_match;

   // The incoming sample plus the stored history must all agree.
   always_comb begin
      all_match = 1'b1;
      for (int i = 0; i < int'(HIST_D); i++) begin
         if (hist_q[i] != sample_i) begin
            all_match = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(HIST_D); i++) begin
            hist_q[i] <= IDLE;
         end
         acc_code_q <= IDLE;
         acc_req_q  <= 1'b0;
      end else begin
         hist_q[0] <= sample_i;
         for (int i = 1; i < int'(HIST_D); i++) begin
            hist_q[i] <= hist_q[i-1];
         end
         if (all_match) begin
            acc_code_q <= sample_i;
            acc_req_q  <= (sample_i != IDLE);
         end
      end
   end

   assign acc_code_o = acc_code_q;
   assign acc_req_o  = acc_req_q;

   // R7: with no full match, the accepted code is held
   a_r7_hold_without_match : assert property (@(posedge clk) disable iff (!rst_n)
      !all_match |=> (acc_code_q == $past(acc_code_q)));

   // R2: on a full match, the latest sample becomes the accepted code
   a_r2_accept_latest : assert property (@(posedge clk) disable iff (!rst_n)
      all_match |=> (acc_code_q == $past(sample_i)));

   // R8: any change of the accepted code agrees with the oldest history entry
   a_r8_change_needs_history : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_code_q != $past(acc_code_q)) |-> (acc_code_q == $past(hist_q[HIST_D-1])));

   // R3: the idle code never carries a request
   a_r3_idle_no_req : assert property (@(posedge clk) disable iff (!rst_n)
      acc_req_q |-> (acc_code_q != IDLE));

endmodule

// File: rtl/elf_code_decode.sv
module elf_code_decode #(
   parameter int unsigned      WIDTH = 4,
   parameter elf_pkg::pin_pol_e PIN_POL = elf_pkg::POL_LOW
) (
   input  logic [WIDTH-1:0] code_i,
   output logic [WIDTH-1:0] level_o
);

   if (PIN_POL == elf_pkg::POL_LOW) begin : g_invert
      assign level_o = ~code_i;
   end else begin : g_direct
      assign level_o = code_i;
   end

endmodule

// File: rtl/elf_level_filter.sv
module elf_level_filter #(
   parameter int unsigned       GROUPS      = 2,
   parameter int unsigned       CODE_W      = 4,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       MATCH_CNT   = 3,
   parameter elf_pkg::pin_pol_e PIN_POL     = elf_pkg::POL_LOW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [GROUPS*CODE_W-1:0] pins_n_i,
   output logic [GROUPS*CODE_W-1:0] level_o,
   output logic [GROUPS-1:0]        req_valid_o
);

   localparam logic [elf_pkg::MAX_CODE_W-1:0] IDLE_FULL = elf_pkg::idle_code(PIN_POL);
   localparam logic [CODE_W-1:0]              IDLE_CODE = IDLE_FULL[CODE_W-1:0];

   if (GROUPS < 1) begin : g_bad_groups
      $error("elf_level_filter: GROUPS must be at least 1");
   end
   if (CODE_W < 1 || CODE_W > elf_pkg::MAX_CODE_W) begin : g_bad_code_w
      $error("elf_level_filter: CODE_W out of range");
   end
   if (SYNC_STAGES > elf_pkg::MAX_SYNC_STAGES) begin : g_bad_sync
      $error("elf_level_filter: SYNC_STAGES too large");
   end
   if (MATCH_CNT < 2) begin : g_bad_match
      $error("elf_level_filter: MATCH_CNT must be at least 2");
   end

   for (genvar g = 0; g < int'(GROUPS); g++) begin : g_grp
      logic [CODE_W-1:0] synced;
      logic [CODE_W-1:0] acc_code;
      logic              acc_req;
      logic [CODE_W-1:0] level;

      elf_pin_sync #(
         .WIDTH   (CODE_W),
         .STAGES  (SYNC_STAGES),
         .RST_VAL (IDLE_CODE)
      ) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pins_n_i[g*CODE_W +: CODE_W]),
         .q_o   (synced)
      );

      elf_match_qual #(
         .WIDTH   (CODE_W),
         .SAMPLES (MATCH_CNT),
         .IDLE    (IDLE_CODE)
      ) i_qual (
         .clk        (clk),
         .rst_n      (rst_n),
         .sample_i   (synced),
         .acc_code_o (acc_code),
         .acc_req_o  (acc_req)
      );

      elf_code_decode #(
         .WIDTH   (CODE_W),
         .PIN_POL (PIN_POL)
      ) i_dec (
         .code_i  (acc_code),
         .level_o (level)
      );

      assign level_o[g*CODE_W +: CODE_W] = level;
      assign req_valid_o[g]              = acc_req;

      // R4: the flag from the qualifier tracks the decoded level
      a_r4_valid_iff_level : assert property (@(posedge clk) disable iff (!rst_n)
         req_valid_o[g] == (level_o[g*CODE_W +: CODE_W] != '0));

      // R1: first cycle out of reset shows no request
      a_r1_reset_quiet : assert property (@(posedge clk)
         !rst_n |=> (level_o[g*CODE_W +: CODE_W] == '0) && !req_valid_o[g]);
   end

endmodule

// File: tb/test_elf_level_filter.sv
module test_elf_level_filter;

   localparam int G = 2;
   localparam int W = 4;
   localparam int LAT = 5;  // 2 synchronizer stages + 3 matching samples

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [G*W-1:0] pins = '1;
   logic [G*W-1:0] level;
   logic [G-1:0]   valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   elf_level_filter i_elf_level_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .pins_n_i    (pins),
      .level_o     (level),
      .req_valid_o (valid)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lvl(input int g);
      return int'(level[g*W +: W]);
   endfunction

   // Behavioural reference: a queue of past pin words, newest first.
   logic [G*W-1:0] hq[$];
   int exp_lvl [G];

   always @(posedge clk) begin
      if (!rst_n) begin
         hq.delete();
         for (int k = 0; k < LAT; k++) hq.push_back('1);
         for (int g = 0; g < G; g++) exp_lvl[g] = 0;
      end else begin
         hq.push_front(pins);
         while (hq.size() > LAT) void'(hq.pop_back());
         for (int g = 0; g < G; g++) begin
            if (hq[2][g*W +: W] == hq[3][g*W +: W] && hq[3][g*W +: W] == hq[4][g*W +: W])
               exp_lvl[g] = int'(~hq[2][g*W +: W]) & 15;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int g = 0; g < G; g++) begin
            chk(lvl(g) == exp_lvl[g], $sformatf("R2 R7 R8 model level g%0d", g), lvl(g), exp_lvl[g]);
            chk(valid[g] == (exp_lvl[g] != 0), $sformatf("R4 model valid g%0d", g),
                int'(valid[g]), int'(exp_lvl[g] != 0));
         end
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // Reset state
      repeat (3) step();
      for (int g = 0; g < G; g++) begin
         chk(lvl(g) == 0, "R1 reset level", lvl(g), 0);
         chk(valid[g] == 1'b0, "R1 reset valid", int'(valid[g]), 0);
      end
      rst_n = 1'b1;
      step();
      chk(lvl(0) == 0 && lvl(1) == 0, "R1 after release", lvl(0) + lvl(1), 0);

      // Latency and all-low decode on group 0
      pins[3:0] = 4'b0000;
      for (int k = 1; k <= LAT; k++) begin
         step();
         if (k < LAT) chk(lvl(0) == 0, "R6 no early update", lvl(0), 0);
         else         chk(lvl(0) == 15, "R2 all-low gives 15", lvl(0), 15);
         chk(lvl(1) == 0, "R5 group 1 untouched", lvl(1), 0);
      end
      chk(valid[0] == 1'b1, "R4 valid with level 15", int'(valid[0]), 1);

      // 1011 gives level 4
      pins[3:0] = 4'b1011;
      repeat (LAT) step();
      chk(lvl(0) == 4, "R2 1011 gives 4", lvl(0), 4);

      // Two-sample glitch is rejected
      pins[3:0] = 4'b0101;
      step();
      step();
      pins[3:0] = 4'b1011;
      for (int k = 0; k < 8; k++) begin
         step();
         chk(lvl(0) == 4, "R7 glitch rejected", lvl(0), 4);
      end

      // Interrupted pattern restarts the count on group 1
      pins[7:4] = 4'b0110;
      step();
      step();
      pins[7:4] = 4'b1110;
      step();
      pins[7:4] = 4'b0110;
      for (int k = 4; k <= 8; k++) begin
         step();
         if (k < 8) chk(lvl(1) == 0, "R8 count restarted", lvl(1), 0);
         else       chk(lvl(1) == 9, "R8 accepted after three", lvl(1), 9);
      end
      chk(lvl(0) == 4, "R5 group 0 kept", lvl(0), 4);

      // All-high means no request
      pins[3:0] = 4'b1111;
      repeat (LAT) step();
      chk(lvl(0) == 0, "R3 all-high level", lvl(0), 0);
      chk(valid[0] == 1'b0, "R3 all-high valid", int'(valid[0]), 0);
      chk(lvl(1) == 9, "R5 group 1 kept", lvl(1), 9);

      // Both groups change together
      pins = 8'b1110_0001;
      repeat (LAT) step();
      chk(lvl(0) == 14, "R5 group 0 concurrent", lvl(0), 14);
      chk(lvl(1) == 1, "R5 group 1 concurrent", lvl(1), 1);
      chk(valid == 2'b11, "R4 both valid", int'(valid), 3);

      // Random phase: short and long holds on both groups
      for (int c = 0; c < 3000; c++) begin
         for (int g = 0; g < G; g++) begin
            if ($urandom_range(0, 2) == 0) pins[g*W +: W] = W'($urandom_range(0, 15));
         end
         step();
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule